// File: doc/BRIEF.md
# Per-Requester Transaction Stall Controller

This block sits in front of the permission check stage and holds back traffic while software rewrites the protection settings. Software marks, in a bitmap indexed by requester ID, which requesters must be paused; every other requester keeps flowing to the check stage in the same cycle, with no register in its path. A transaction from a paused requester is either held at the gate (valid stays high upstream, ready stays low) or, when the fault-on-stall bit is set, consumed at once and reported as a fault with error type 0x7, never to be resumed.

An update runs in three phases: software loads the bitmap and waits for the status outputs to report that every paused requester has no transaction still inside the check stage, then changes the settings, then clears the bitmap and pulses resume. An invert bit flips the sense of the bitmap, so that marked IDs are the exempt ones and all others pause. The block counts, per ID, transactions handed to the check stage and not yet completed, which is what the status outputs report on.

Top module: `stall_ctrl`

## Requirements
- R1: Out of reset the pause mask is all zero, every requester passes, `flt_valid`, `query_stalled` and `all_stalled` are 0 and every in-flight count is zero.
- R2: The effective bitmap is `stall_sel[i] XOR stall_invert`; on each clock edge without resume it is ORed into the pause mask, so a pause takes effect one cycle after it is requested and stays set after the bitmap is cleared.
- R3: A transaction whose ID is not in the pause mask passes in the same cycle: `dn_valid` equals `up_valid`, `up_ready` equals `dn_ready`, and ID and data are forwarded unchanged.
- R4: A transaction whose ID is in the pause mask with `fault_en` = 0 is held: `dn_valid` = 0, `up_ready` = 0, `flt_valid` = 0, for as long as the mask bit stays set.
- R5: A transaction whose ID is in the pause mask with `fault_en` = 1 is faulted: `up_ready` = 1, `dn_valid` = 0, `flt_valid` = 1, `flt_id` = `up_id`, `flt_etype` = 4'h7.
- R6: A clock edge with `resume` = 1 clears the whole pause mask (the bitmap is not merged on that edge); a held transaction is then offered downstream in the next cycle if its ID is not selected again.
- R7: Each ID keeps a count of transactions accepted downstream (`dn_valid` and `dn_ready`) minus completions (`cpl_valid` with `cpl_id`); an accept and a completion for the same ID on one edge leave it unchanged.
- R8: `query_stalled` is 1 exactly when the ID on `query_id` is in the pause mask and its in-flight count is zero.
- R9: `all_stalled` is 1 exactly when the pause mask is non-zero and every ID in it has an in-flight count of zero.
- R10: With `stall_invert` = 1, IDs whose bitmap bit is 1 are exempt and are never held or faulted, while IDs whose bit is 0 pause.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stall_sel | input | N_IDS | Pause bitmap, one bit per requester ID |
| stall_invert | input | 1 | 1: bitmap marks exempt IDs instead of paused ones |
| fault_en | input | 1 | 1: fault paused transactions instead of holding them |
| resume | input | 1 | Pulse: clear the pause mask |
| up_valid | input | 1 | Incoming transaction valid |
| up_ready | output | 1 | Incoming transaction accepted |
| up_id | input | ID_W | Requester ID of incoming transaction |
| up_data | input | DATA_W | Transaction payload |
| dn_valid | output | 1 | Transaction offered to the check stage |
| dn_ready | input | 1 | Check stage accepts |
| dn_id | output | ID_W | Requester ID toward the check stage |
| dn_data | output | DATA_W | Payload toward the check stage |
| cpl_valid | input | 1 | A transaction finished in the check stage |
| cpl_id | input | ID_W | Requester ID of the finished transaction |
| flt_valid | output | 1 | A paused transaction was faulted this cycle |
| flt_id | output | ID_W | Requester ID of the faulted transaction |
| flt_etype | output | 4 | Error type of the fault, always 0x7 |
| query_id | input | ID_W | Requester ID whose pause state is queried |
| query_stalled | output | 1 | Queried ID is paused and has nothing in flight |
| all_stalled | output | 1 | Every paused ID has nothing in flight |

## Verification
The bench sweeps every bitmap, invert setting, requester ID, fault setting and downstream ready for a four-ID configuration, so a gate that decoded the mask with the wrong index or polarity would pass a paused requester or hold an exempt one. Directed sequences aim at the status outputs while transactions are still in the check stage: a tracker that ignored completions, or that dropped the decrement when an accept and a completion land on one edge, would report a pause complete too early or never. Other sequences check that a held transaction stays blocked through the resume cycle and leaves the next cycle, and that clearing the bitmap without resume keeps the pause, which a mask wired straight to the input would lose.

// File: rtl/stall_pkg.sv
// Package: shared constants for the stall controller.
// Assumes a 4-bit error type field toward the error logger.
package stall_pkg;
    localparam int ETYPE_W = 4;
    typedef logic [ETYPE_W-1:0] etype_t;
    // Error type reported for a transaction faulted while paused.
    localparam etype_t ETYPE_STALL_FAULT = 4'h7;
endpackage

// File: rtl/stall_mask_reg.sv
// Module: stall_mask_reg
// Holds the sticky pause mask. The effective bitmap is merged in on every
// edge; a resume edge clears the mask and skips the merge.
// Assumes resume is a single-cycle command from software.
module stall_mask_reg #(
    parameter int N_IDS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IDS-1:0] eff_mask,
    input  logic             resume,
    output logic [N_IDS-1:0] stall_mask
);
    // Accumulate requested pauses; clear on resume or reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stall_mask <= '0;
        end else if (resume) begin
            stall_mask <= '0;
        end else begin
            stall_mask <= stall_mask | eff_mask;
        end
    end
endmodule

// File: rtl/stall_gate.sv
// Module: stall_gate
// Combinational routing of one transaction: pass, hold or fault depending
// on the pause mask bit of its requester ID. No register in the pass path.
// Assumes upstream keeps valid and payload stable while ready is low.
module stall_gate
    import stall_pkg::*;
#(
    parameter int ID_W   = 2,
    parameter int DATA_W = 16,
    localparam int N_IDS = 1 << ID_W
) (
    input  logic [N_IDS-1:0]  stall_mask,
    input  logic              fault_en,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic [ID_W-1:0]   up_id,
    input  logic [DATA_W-1:0] up_data,
    output logic              dn_valid,
    input  logic              dn_ready,
    output logic [ID_W-1:0]   dn_id,
    output logic [DATA_W-1:0] dn_data,
    output logic              flt_valid,
    output logic [ID_W-1:0]   flt_id,
    output etype_t            flt_etype
);
    logic hit;

    // Decide pass, hold or fault for the transaction at the gate.
    always_comb begin
        hit       = stall_mask[up_id];
        dn_valid  = up_valid & ~hit;
        up_ready  = hit ? fault_en : dn_ready;
        flt_valid = up_valid & hit & fault_en;
        dn_id     = up_id;
        dn_data   = up_data;
        flt_id    = up_id;
        flt_etype = ETYPE_STALL_FAULT;
    end
endmodule

// File: rtl/inflight_tracker.sv
// Module: inflight_tracker
// One counter per requester ID of transactions handed to the check stage
// and not yet completed; flags each ID that has something in flight.
// Assumes no more than 2**CNT_W-1 outstanding per ID and no completion
// for an ID with nothing outstanding.
module inflight_tracker #(
    parameter int ID_W  = 2,
    parameter int CNT_W = 4,
    localparam int N_IDS = 1 << ID_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic [ID_W-1:0]  acc_id,
    input  logic             cpl_valid,
    input  logic [ID_W-1:0]  cpl_id,
    output logic [N_IDS-1:0] busy
);
    for (genvar g = 0; g < N_IDS; g++) begin : g_cnt
        logic [CNT_W-1:0] cnt;
        logic             inc;
        logic             dec;

        // Select increment and decrement for this ID.
        always_comb begin
            inc = acc_valid && (acc_id == ID_W'(g));
            dec = cpl_valid && (cpl_id == ID_W'(g));
        end

        // Update the outstanding count; same-edge inc and dec cancel.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt <= '0;
            end else if (inc && !dec) begin
                cnt <= cnt + 1'b1;
            end else if (dec && !inc) begin
                cnt <= cnt - 1'b1;
            end
        end

        // Report whether this ID has anything in flight.
        always_comb begin
            busy[g] = (cnt != '0);
        end
    end
endmodule

// File: rtl/stall_ctrl.sv
// Module: stall_ctrl (top)
// Per-requester pause gate in front of the permission check stage, with
// hold or fault behaviour and status telling software when all paused
// requesters have drained. Synchronous active-low reset.
// Assumes the check stage reports every accepted transaction exactly once
// on the completion port.
module stall_ctrl
    import stall_pkg::*;
#(
    parameter int ID_W   = 2,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 4,
    localparam int N_IDS = 1 << ID_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IDS-1:0]  stall_sel,
    input  logic              stall_invert,
    input  logic              fault_en,
    input  logic              resume,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic [ID_W-1:0]   up_id,
    input  logic [DATA_W-1:0] up_data,
    output logic              dn_valid,
    input  logic              dn_ready,
    output logic [ID_W-1:0]   dn_id,
    output logic [DATA_W-1:0] dn_data,
    input  logic              cpl_valid,
    input  logic [ID_W-1:0]   cpl_id,
    output logic              flt_valid,
    output logic [ID_W-1:0]   flt_id,
    output logic [ETYPE_W-1:0] flt_etype,
    input  logic [ID_W-1:0]   query_id,
    output logic              query_stalled,
    output logic              all_stalled
);
    logic [N_IDS-1:0] eff_mask;
    logic [N_IDS-1:0] stall_mask;
    logic [N_IDS-1:0] busy;
    logic             acc_valid;

    // Apply the invert bit to the software bitmap.
    always_comb begin
        eff_mask = stall_sel ^ {N_IDS{stall_invert}};
    end

    stall_mask_reg #(.N_IDS(N_IDS)) u_mask (
        .clk        (clk),
        .rst_n      (rst_n),
        .eff_mask   (eff_mask),
        .resume     (resume),
        .stall_mask (stall_mask)
    );

    stall_gate #(.ID_W(ID_W), .DATA_W(DATA_W)) u_gate (
        .stall_mask (stall_mask),
        .fault_en   (fault_en),
        .up_valid   (up_valid),
        .up_ready   (up_ready),
        .up_id      (up_id),
        .up_data    (up_data),
        .dn_valid   (dn_valid),
        .dn_ready   (dn_ready),
        .dn_id      (dn_id),
        .dn_data    (dn_data),
        .flt_valid  (flt_valid),
        .flt_id     (flt_id),
        .flt_etype  (flt_etype)
    );

    // A handshake toward the check stage puts one transaction in flight.
    always_comb begin
        acc_valid = dn_valid & dn_ready;
    end

    inflight_tracker #(.ID_W(ID_W), .CNT_W(CNT_W)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .acc_id    (dn_id),
        .cpl_valid (cpl_valid),
        .cpl_id    (cpl_id),
        .busy      (busy)
    );

    // Drained status for one queried ID and for the whole paused set.
    always_comb begin
        query_stalled = stall_mask[query_id] & ~busy[query_id];
        all_stalled   = (|stall_mask) & ~(|(stall_mask & busy));
    end
endmodule

// File: rtl/stall_ctrl_chk.sv
// Module: stall_ctrl_chk
// Property checker attached to stall_ctrl by bind; observes ports and the
// pause mask, effective bitmap and busy flags inside the top.
module stall_ctrl_chk #(
    parameter int ID_W = 2,
    localparam int N_IDS = 1 << ID_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_IDS-1:0] eff_mask,
    input logic [N_IDS-1:0] stall_mask,
    input logic [N_IDS-1:0] busy,
    input logic             fault_en,
    input logic             resume,
    input logic             up_valid,
    input logic             up_ready,
    input logic [ID_W-1:0]  up_id,
    input logic             dn_valid,
    input logic             dn_ready,
    input logic             cpl_valid,
    input logic [ID_W-1:0]  cpl_id,
    input logic             flt_valid,
    input logic [ID_W-1:0]  flt_id,
    input logic [3:0]       flt_etype,
    input logic [ID_W-1:0]  query_id,
    input logic             query_stalled,
    input logic             all_stalled
);
    assert_merge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !resume |=> ((stall_mask & $past(eff_mask)) == $past(eff_mask)));

    assert_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && !stall_mask[up_id]) |-> (dn_valid && (up_ready == dn_ready)));

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && stall_mask[up_id] && !fault_en) |-> (!dn_valid && !up_ready && !flt_valid));

    assert_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |-> (flt_etype == 4'h7 && !dn_valid && up_ready && flt_id == up_id));

    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        resume |=> (stall_mask == '0));

    assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |-> busy[cpl_id]);

    assert_query_R8: assert property (@(posedge clk) disable iff (!rst_n)
        query_stalled |-> (stall_mask[query_id] && !busy[query_id]));

    assert_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
        all_stalled |-> ((stall_mask != '0) && ((stall_mask & busy) == '0)));
endmodule

bind stall_ctrl stall_ctrl_chk #(.ID_W(ID_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .eff_mask      (eff_mask),
    .stall_mask    (stall_mask),
    .busy          (busy),
    .fault_en      (fault_en),
    .resume        (resume),
    .up_valid      (up_valid),
    .up_ready      (up_ready),
    .up_id         (up_id),
    .dn_valid      (dn_valid),
    .dn_ready      (dn_ready),
    .cpl_valid     (cpl_valid),
    .cpl_id        (cpl_id),
    .flt_valid     (flt_valid),
    .flt_id        (flt_id),
    .flt_etype     (flt_etype),
    .query_id      (query_id),
    .query_stalled (query_stalled),
    .all_stalled   (all_stalled)
);

// File: tb/stall_ctrl_tb.sv
// Bench for stall_ctrl: exhaustive gate sweep over a four-ID configuration
// plus directed sequences for drain status, hold/resume and sticky mask.
module stall_ctrl_tb;
    localparam int ID_W   = 2;
    localparam int DATA_W = 16;
    localparam int N_IDS  = 1 << ID_W;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [N_IDS-1:0]  stall_sel;
    logic              stall_invert;
    logic              fault_en;
    logic              resume;
    logic              up_valid;
    logic              up_ready;
    logic [ID_W-1:0]   up_id;
    logic [DATA_W-1:0] up_data;
    logic              dn_valid;
    logic              dn_ready;
    logic [ID_W-1:0]   dn_id;
    logic [DATA_W-1:0] dn_data;
    logic              cpl_valid;
    logic [ID_W-1:0]   cpl_id;
    logic              flt_valid;
    logic [ID_W-1:0]   flt_id;
    logic [3:0]        flt_etype;
    logic [ID_W-1:0]   query_id;
    logic              query_stalled;
    logic              all_stalled;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    stall_ctrl #(.ID_W(ID_W), .DATA_W(DATA_W), .CNT_W(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .stall_sel(stall_sel), .stall_invert(stall_invert),
        .fault_en(fault_en), .resume(resume), .up_valid(up_valid), .up_ready(up_ready),
        .up_id(up_id), .up_data(up_data), .dn_valid(dn_valid), .dn_ready(dn_ready),
        .dn_id(dn_id), .dn_data(dn_data), .cpl_valid(cpl_valid), .cpl_id(cpl_id),
        .flt_valid(flt_valid), .flt_id(flt_id), .flt_etype(flt_etype),
        .query_id(query_id), .query_stalled(query_stalled), .all_stalled(all_stalled)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; stall_sel = '0; stall_invert = 1'b0; fault_en = 1'b0;
        resume = 1'b0; up_valid = 1'b0; up_id = '0; up_data = '0; dn_ready = 1'b1;
        cpl_valid = 1'b0; cpl_id = '0; query_id = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        up_valid = 1'b1; up_id = 2'd2; up_data = 16'h1234; #2;
        check("R1 dn_valid", dn_valid, 1);
        check("R1 flt_valid", flt_valid, 0);
        check("R1 query_stalled", query_stalled, 0);
        check("R1 all_stalled", all_stalled, 0);
        up_valid = 1'b0;

        // R3/R4/R5/R10: sweep bitmap, invert, fault, ready, ID
        for (int sel = 0; sel < 16; sel++) begin
            for (int inv = 0; inv < 2; inv++) begin
                @(negedge clk);
                stall_sel = sel[3:0]; stall_invert = inv[0]; resume = 1'b1;
                @(negedge clk);
                resume = 1'b0;
                @(negedge clk);
                for (int fe = 0; fe < 2; fe++) begin
                    for (int rdy = 0; rdy < 2; rdy++) begin
                        for (int id = 0; id < N_IDS; id++) begin
                            logic [3:0] eff;
                            logic       hit;
                            eff = sel[3:0] ^ {4{inv[0]}};
                            hit = eff[id];
                            fault_en = fe[0]; dn_ready = rdy[0];
                            up_id = id[1:0]; up_data = 16'(sel * 37 + id * 5 + inv);
                            up_valid = 1'b1;
                            #1;
                            if (!hit) begin
                                check(inv ? "R10 pass dn_valid" : "R3 pass dn_valid", dn_valid, 1);
                                check("R3 up_ready", up_ready, rdy);
                                check("R3 dn_data", dn_data, 16'(sel * 37 + id * 5 + inv));
                                check("R3 dn_id", dn_id, id);
                                check("R3 flt_valid", flt_valid, 0);
                            end else if (fe == 0) begin
                                check(inv ? "R10 hold dn_valid" : "R4 hold dn_valid", dn_valid, 0);
                                check("R4 up_ready", up_ready, 0);
                                check("R4 flt_valid", flt_valid, 0);
                            end else begin
                                check("R5 flt_valid", flt_valid, 1);
                                check("R5 up_ready", up_ready, 1);
                                check("R5 dn_valid", dn_valid, 0);
                                check("R5 flt_etype", flt_etype, 4'h7);
                                check("R5 flt_id", flt_id, id);
                            end
                            up_valid = 1'b0;
                            #1;
                        end
                    end
                end
            end
        end

        // Clean slate for directed tests
        @(negedge clk);
        stall_sel = '0; stall_invert = 1'b0; fault_en = 1'b0; dn_ready = 1'b1; resume = 1'b1;
        @(negedge clk);
        resume = 1'b0;

        // R7/R8/R9: two transactions of ID 1 in flight, then pause ID 1
        up_valid = 1'b1; up_id = 2'd1;
        @(negedge clk);
        @(negedge clk);
        up_valid = 1'b0; stall_sel = 4'b0010;
        @(negedge clk);
        query_id = 2'd1; #2;
        check("R8 busy query", query_stalled, 0);
        check("R9 busy all", all_stalled, 0);
        up_valid = 1'b1; up_id = 2'd2; #1;
        check("R3 other ID during pause", dn_valid, 1);
        up_valid = 1'b0;
        cpl_valid = 1'b1; cpl_id = 2'd1;
        @(negedge clk);
        #2;
        check("R8 one left query", query_stalled, 0);
        check("R9 one left all", all_stalled, 0);
        @(negedge clk);
        cpl_valid = 1'b0; #2;
        check("R8 drained query", query_stalled, 1);
        check("R9 drained all", all_stalled, 1);
        query_id = 2'd0; #1;
        check("R8 unpaused ID", query_stalled, 0);

        // R4/R6: hold then release on resume
        up_valid = 1'b1; up_id = 2'd1; up_data = 16'hBEEF;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); #2;
            check("R4 held over cycles", {30'd0, dn_valid, up_ready}, 0);
        end
        stall_sel = '0; resume = 1'b1; #2;
        check("R6 held in resume cycle", dn_valid, 0);
        @(negedge clk);
        resume = 1'b0; #2;
        check("R6 released dn_valid", dn_valid, 1);
        check("R6 released data", dn_data, 16'hBEEF);
        @(negedge clk);
        up_valid = 1'b0; cpl_valid = 1'b1; cpl_id = 2'd1;
        @(negedge clk);
        cpl_valid = 1'b0;

        // R7: accept and completion on one edge cancel
        up_valid = 1'b1; up_id = 2'd3;
        @(negedge clk);
        cpl_valid = 1'b1; cpl_id = 2'd3;
        @(negedge clk);
        up_valid = 1'b0;
        @(negedge clk);
        cpl_valid = 1'b0; stall_sel = 4'b1000;
        @(negedge clk);
        query_id = 2'd3; #2;
        check("R7 same-edge inc/dec", query_stalled, 1);

        // R2: clearing the bitmap without resume keeps the pause
        stall_sel = '0;
        @(negedge clk);
        #2;
        check("R2 sticky mask", query_stalled, 1);
        up_valid = 1'b1; up_id = 2'd3; #1;
        check("R2 sticky hold", dn_valid, 0);
        up_valid = 1'b0;
        resume = 1'b1;
        @(negedge clk);
        resume = 1'b0; #2;
        check("R6 mask cleared", query_stalled, 0);
        check("R6 all clear", all_stalled, 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule